// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block holds the interrupt bookkeeping of an SD host controller: a raw status word fed by single-cycle event pulses from the command and data engines, a 32-bit interrupt mask, a global interrupt enable and a card-present flag that follows a card-detect pin. It drives one level-sensitive interrupt line toward the system interrupt controller.

Software reaches the block through a simple 32-bit register port. It has a write strobe, a byte address and write data, and read data follows the address combinationally. Status bits are cleared by writing ones, either at the raw status address or at the masked status address. The command sequencer, the DMA engine and the card signalling are outside this block. They only deliver pulses, and they read the interrupt line.

Top module: `sdirq_unit`

## Requirements
- R1: After reset the control register reads 0, the mask reads 0, raw and masked status read 0, the card status register (offset 0x10) reads 0x100 and `irq_o` is low.
- R2: A pulse on an event input sets its raw status bit at the next clock edge: command complete bit 2, no response bit 1, data complete bit 3, auto-command done bit 14, SDIO bit 16. Other raw bits stay as they were.
- R3: A write to the raw status address (offset 0x0C) clears each raw bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to the masked status address (offset 0x08) clears raw bits with the same write-one rule as R3.
- R5: A read of the masked status address returns raw status AND mask.
- R6: `irq_o` is high exactly when control bit 4 (offset 0x00) is set and raw status AND mask is nonzero. It follows a register write or an event on the clock edge that updates the state.
- R7: A rising card-detect level, after a two-flop synchronizer, sets raw bit 30, clears raw bit 31 and sets card status bit 8. A falling level sets bit 31, clears bit 30 and clears bit 8. The registers show the change on the third clock edge after the pin changes. Bits 30 and 31 are never both set.
- R8: When an event pulse and a write-one clear hit the same raw bit in the same cycle, the bit ends up set.
- R9: Writes to the card status address leave it unchanged. Raw bits other than 1, 2, 3, 14, 16, 30 and 31 always read 0. Offsets 0x14 to 0x1C read 0.
- R10: The mask reads back all 32 written bits. The control register reads back only bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (5) | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_cmd_done_i | input | 1 | Command complete pulse |
| evt_no_resp_i | input | 1 | No response pulse |
| evt_data_done_i | input | 1 | Data complete pulse |
| evt_auto_done_i | input | 1 | Auto-command done pulse |
| evt_sdio_i | input | 1 | SDIO interrupt pulse |
| card_det_i | input | 1 | Asynchronous card-detect level, high when a card is present |
| irq_o | output | 1 | Level interrupt request |
| card_present_o | output | 1 | Card-present flag, same as card status bit 8 |

## Verification
Register writes and event pulses reach the state at the first rising edge after they are driven. Read data and `irq_o` follow the registers combinationally, so the bench drives on falling edges and samples in the low half of the next cycle. Card-detect changes go through two synchronizer flops and an edge register, so the bench looks at the registers after the second edge to confirm that nothing has moved yet, and after the third edge to confirm the change. The bench drives same-cycle event and clear collisions in one cycle and reads the result one cycle later.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_EVT = 5;

    // raw status bit positions (software decodes these)
    localparam int BIT_NO_RESP   = 1;
    localparam int BIT_CMD_DONE  = 2;
    localparam int BIT_DATA_DONE = 3;
    localparam int BIT_AUTO_DONE = 14;
    localparam int BIT_SDIO      = 16;
    localparam int BIT_CARD_IN   = 30;
    localparam int BIT_CARD_OUT  = 31;
    localparam int BIT_IRQ_EN    = 4;
    localparam int BIT_PRESENT   = 8;

    // event index -> raw bit position
    localparam int EVT_POS [NUM_EVT] = '{BIT_CMD_DONE, BIT_NO_RESP, BIT_DATA_DONE,
                                         BIT_AUTO_DONE, BIT_SDIO};

    // word offsets (byte offset / 4)
    localparam int WORD_CTRL  = 0;
    localparam int WORD_MASK  = 1;
    localparam int WORD_MSTAT = 2;
    localparam int WORD_RSTAT = 3;
    localparam int WORD_CSTAT = 4;

    function automatic logic [DATA_W-1:0] raw_impl_bits();
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_EVT; i++) v[EVT_POS[i]] = 1'b1;
        v[BIT_CARD_IN]  = 1'b1;
        v[BIT_CARD_OUT] = 1'b1;
        return v;
    endfunction

    typedef struct packed {
        logic              irq_en;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] raw;
        logic              present;
    } irq_state_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_mask;
        logic wr_clear;
    } wr_sel_t;

endpackage

// File: rtl/sdirq_cd_sync.sv
module sdirq_cd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic card_det_i,
    output logic insert_o,
    output logic remove_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        level_now, level_old;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], card_det_i};
    end

    // reset to "present" so a card seated at reset raises no event
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{chain: '1};
        else         st_q <= st_d;
    end

    assign level_now = st_q.chain[STAGES-1];
    assign level_old = st_q.chain[STAGES];
    assign insert_o  = level_now & ~level_old;
    assign remove_o  = ~level_now & level_old;

endmodule

// File: rtl/sdirq_status.sv
module sdirq_status
    import sdirq_pkg::*;
#(
    parameter int NEVT = NUM_EVT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  wr_sel_t           sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NEVT-1:0]   evt_i,
    input  logic              insert_i,
    input  logic              remove_i,
    output logic              irq_en_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] raw_o,
    output logic              present_o
);
    localparam logic [DATA_W-1:0] RAW_IMPL = raw_impl_bits();

    irq_state_t        st_d, st_q;
    logic [DATA_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NEVT; i++) begin
            if (evt_i[i]) set_vec[EVT_POS[i]] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (sel_i.wr_ctrl) st_d.irq_en = wdata_i[BIT_IRQ_EN];
        if (sel_i.wr_mask) st_d.mask   = wdata_i;
        // write-one clear first, hardware sets afterwards: events win
        if (sel_i.wr_clear) st_d.raw = st_q.raw & ~wdata_i;
        st_d.raw = st_d.raw | set_vec;
        if (insert_i) begin
            st_d.raw[BIT_CARD_IN]  = 1'b1;
            st_d.raw[BIT_CARD_OUT] = 1'b0;
            st_d.present           = 1'b1;
        end else if (remove_i) begin
            st_d.raw[BIT_CARD_IN]  = 1'b0;
            st_d.raw[BIT_CARD_OUT] = 1'b1;
            st_d.present           = 1'b0;
        end
        st_d.raw = st_d.raw & RAW_IMPL;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{irq_en: 1'b0, mask: '0, raw: '0, present: 1'b1};
        else         st_q <= st_d;
    end

    assign irq_en_o  = st_q.irq_en;
    assign mask_o    = st_q.mask;
    assign raw_o     = st_q.raw;
    assign present_o = st_q.present;

endmodule

// File: rtl/sdirq_regif.sv
module sdirq_regif
    import sdirq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              irq_en_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] raw_i,
    input  logic              present_i,
    output wr_sel_t           sel_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] masked;

    assign word   = addr_i[ADDR_W-1:2];
    assign masked = raw_i & mask_i;

    always_comb begin
        sel_o          = '0;
        sel_o.wr_ctrl  = wr_i && (word == WORD_W'(WORD_CTRL));
        sel_o.wr_mask  = wr_i && (word == WORD_W'(WORD_MASK));
        sel_o.wr_clear = wr_i && ((word == WORD_W'(WORD_MSTAT)) ||
                                  (word == WORD_W'(WORD_RSTAT)));
    end

    always_comb begin
        rdata_o = '0;
        case (word)
            WORD_W'(WORD_CTRL):  rdata_o[BIT_IRQ_EN]  = irq_en_i;
            WORD_W'(WORD_MASK):  rdata_o              = mask_i;
            WORD_W'(WORD_MSTAT): rdata_o              = masked;
            WORD_W'(WORD_RSTAT): rdata_o              = raw_i;
            WORD_W'(WORD_CSTAT): rdata_o[BIT_PRESENT] = present_i;
            default:             rdata_o              = '0;
        endcase
    end

    assign irq_o = irq_en_i & (|masked);

endmodule

// File: rtl/sdirq_unit.sv
module sdirq_unit
    import sdirq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              evt_cmd_done_i,
    input  logic              evt_no_resp_i,
    input  logic              evt_data_done_i,
    input  logic              evt_auto_done_i,
    input  logic              evt_sdio_i,
    input  logic              card_det_i,
    output logic              irq_o,
    output logic              card_present_o
);
    wr_sel_t           sel_w;
    logic [NUM_EVT-1:0] evt_w;
    logic              insert_w, remove_w, irq_en_w;
    logic [DATA_W-1:0] mask_w, raw_w;

    // order follows EVT_POS
    assign evt_w = {evt_sdio_i, evt_auto_done_i, evt_data_done_i,
                    evt_no_resp_i, evt_cmd_done_i};

    sdirq_cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .card_det_i (card_det_i),
        .insert_o   (insert_w),
        .remove_o   (remove_w)
    );

    sdirq_status #(.NEVT(NUM_EVT)) u_stat (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (sel_w),
        .wdata_i   (reg_wdata_i),
        .evt_i     (evt_w),
        .insert_i  (insert_w),
        .remove_i  (remove_w),
        .irq_en_o  (irq_en_w),
        .mask_o    (mask_w),
        .raw_o     (raw_w),
        .present_o (card_present_o)
    );

    sdirq_regif #(.ADDR_W(ADDR_W)) u_regif (
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .irq_en_i  (irq_en_w),
        .mask_i    (mask_w),
        .raw_i     (raw_w),
        .present_i (card_present_o),
        .sel_o     (sel_w),
        .rdata_o   (reg_rdata_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/sdirq_unit_chk.sv
module sdirq_unit_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic              evt_cmd_done_i,
    input logic              evt_no_resp_i,
    input logic              evt_data_done_i,
    input logic              evt_auto_done_i,
    input logic              evt_sdio_i,
    input logic              irq_o,
    input logic              card_present_o,
    input logic [31:0]       raw_i
);
    logic wr_ctrl, wr_rstat, wr_mstat;
    assign wr_ctrl  = reg_wr_i && (reg_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(0));
    assign wr_mstat = reg_wr_i && (reg_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(2));
    assign wr_rstat = reg_wr_i && (reg_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(3));

    assert_cmd_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_cmd_done_i |=> raw_i[2]);
    assert_noresp_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_no_resp_i |=> raw_i[1]);
    assert_sdio_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_sdio_i && wr_rstat) |=> raw_i[16]);
    assert_data_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_data_done_i && (wr_rstat || wr_mstat)) |=> raw_i[3]);
    assert_raw_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_rstat && reg_wdata_i[3] && !evt_data_done_i) |=> !raw_i[3]);
    assert_masked_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_mstat && reg_wdata_i[14] && !evt_auto_done_i) |=> !raw_i[14]);
    assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ctrl && !reg_wdata_i[4]) |=> !irq_o);
    assert_card_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(raw_i[31:30]));
    assert_card_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(card_present_o) |-> (raw_i[30] && !raw_i[31]));
    assert_card_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(card_present_o) |-> (raw_i[31] && !raw_i[30]));

endmodule

bind sdirq_unit sdirq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_wr_i        (reg_wr_i),
    .reg_addr_i      (reg_addr_i),
    .reg_wdata_i     (reg_wdata_i),
    .evt_cmd_done_i  (evt_cmd_done_i),
    .evt_no_resp_i   (evt_no_resp_i),
    .evt_data_done_i (evt_data_done_i),
    .evt_auto_done_i (evt_auto_done_i),
    .evt_sdio_i      (evt_sdio_i),
    .irq_o           (irq_o),
    .card_present_o  (card_present_o),
    .raw_i           (raw_w)
);

// File: tb/sdirq_unit_bench.sv
module sdirq_unit_bench;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_CTRL = 5'h00, A_MASK = 5'h04, A_MST = 5'h08,
                              A_RST = 5'h0C, A_CST = 5'h10;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0, rdata;
    logic [4:0]    evt = '0;
    logic          card = 1'b1, irq, present;
    int            checks = 0, errors = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    sdirq_unit u_sdirq_unit (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .evt_cmd_done_i(evt[0]), .evt_no_resp_i(evt[1]), .evt_data_done_i(evt[2]),
        .evt_auto_done_i(evt[3]), .evt_sdio_i(evt[4]),
        .card_det_i(card), .irq_o(irq), .card_present_o(present));

    // event index -> raw bit, from R2
    function automatic logic [31:0] evt_bits(logic [4:0] e);
        logic [31:0] v = '0;
        v[2] = e[0]; v[1] = e[1]; v[3] = e[2]; v[14] = e[3]; v[16] = e[4];
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, state updates at the following posedge
    task automatic cyc(logic w, logic [AW-1:0] a, logic [31:0] d, logic [4:0] e);
        @(negedge clk);
        wr = w; addr = a; wdata = d; evt = e;
        @(negedge clk);
        wr = 1'b0; evt = '0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    initial begin
        logic [31:0] v, exp_raw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_MASK, v); check("R1 mask", v, 0);
        rd(A_RST, v);  check("R1 raw", v, 0);
        rd(A_MST, v);  check("R1 masked", v, 0);
        rd(A_CST, v);  check("R1 card status", v, 32'h100);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 sweep of every event combination
        for (int s = 0; s < 32; s++) begin
            cyc(1'b1, A_RST, 32'hFFFF_FFFF, '0);
            cyc(1'b0, A_CTRL, 0, 5'(s));
            rd(A_RST, v); check("R2 event set", v, evt_bits(5'(s)));
        end

        // R10 / R5 / R6 sweep: all five event bits set, each mask bit, enable on/off
        cyc(1'b0, A_CTRL, 0, 5'h1F);
        exp_raw = evt_bits(5'h1F);
        for (int en = 0; en < 2; en++) begin
            cyc(1'b1, A_CTRL, en ? 32'hFFFF_FFFF : 32'h0, '0);
            rd(A_CTRL, v); check("R10 ctrl readback", v, en ? 32'h10 : 32'h0);
            for (int k = 0; k < 32; k++) begin
                cyc(1'b1, A_MASK, 32'h1 << k, '0);
                rd(A_MASK, v); check("R10 mask readback", v, 32'h1 << k);
                rd(A_MST, v);  check("R5 masked", v, exp_raw & (32'h1 << k));
                check("R6 irq", {31'b0, irq},
                      {31'b0, (en == 1) && ((exp_raw & (32'h1 << k)) != 0)});
            end
        end

        // R6 enable drop with a pending masked bit
        cyc(1'b1, A_MASK, 32'h4, '0);
        check("R6 irq pending", {31'b0, irq}, 1);
        cyc(1'b1, A_CTRL, 0, '0);
        check("R6 irq gated", {31'b0, irq}, 0);

        // R3 / R4 write-one clear
        cyc(1'b1, A_RST, 32'h0000_0004, '0);
        exp_raw &= ~32'h4;
        rd(A_RST, v); check("R3 raw clear", v, exp_raw);
        cyc(1'b1, A_RST, 32'h0, '0);
        rd(A_RST, v); check("R3 zero write", v, exp_raw);
        cyc(1'b1, A_MST, 32'h0001_0008, '0);
        exp_raw &= ~32'h0001_0008;
        rd(A_RST, v); check("R4 masked clear", v, exp_raw);

        // R8 collision
        cyc(1'b1, A_RST, 32'hFFFF_FFFF, 5'h01);
        rd(A_RST, v); check("R8 event beats clear", v, 32'h4);
        cyc(1'b1, A_MST, 32'hFFFF_FFFF, 5'h08);
        rd(A_RST, v); check("R8 event beats masked clear", v, 32'h4000);
        cyc(1'b1, A_RST, 32'hFFFF_FFFF, '0);

        // R7 removal, boundary at the second edge
        @(negedge clk); card = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(A_CST, v); check("R7 not yet removed", v, 32'h100);
        @(negedge clk);
        rd(A_RST, v); check("R7 remove raw", v, 32'h8000_0000);
        rd(A_CST, v); check("R7 remove status", v, 32'h0);
        check("R7 present low", {31'b0, present}, 0);
        card = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_RST, v); check("R7 not yet inserted", v, 32'h8000_0000);
        @(negedge clk);
        rd(A_RST, v); check("R7 insert raw", v, 32'h4000_0000);
        rd(A_CST, v); check("R7 insert status", v, 32'h100);

        // R9 ignored writes and unmapped reads
        cyc(1'b1, A_CST, 32'h0, '0);
        rd(A_CST, v); check("R9 status write ignored", v, 32'h100);
        cyc(1'b1, A_RST, 32'hFFFF_FFFF, 5'h1F);
        rd(A_RST, v); check("R9 unimplemented raw bits", v & ~32'hC001_400E, 0);
        for (int a = 5; a < 8; a++) begin
            rd(AW'(a * 4), v); check("R9 unmapped read", v, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule